// File: doc/BRIEF.md
# Machine-Cycle Timing, Reset Qualifier and Low-Power Mode Controller

This block generates the internal timing of a small 8-bit controller core from one oscillator clock. A toggle stage halves the oscillator rate, so the external duty cycle does not matter. A state counter then splits every twelve oscillator periods into one machine cycle. The block emits a one-clock strobe at each machine-cycle boundary. It also drives two clock enables: one for the CPU and one for the timers, serial port and interrupt logic.

The raw reset pin is handled in two stages. The port preset follows the pin straight away, so all port outputs go high at once. The internal reset waits until the pin has stayed high for two full machine cycles. The block also holds the two low-power request bits of the power-control register. Idle stops only the CPU enable, and an enabled interrupt or a reset ends it. Power-down freezes every enable, and only a reset ends it. Reset clears the special registers but never touches RAM.

Top module: `clkpwr_ctrl`

## Requirements
- R1: While the block runs (no internal reset and not in power-down), `periph_en` is a one-clock pulse on every second oscillator clock. It is never high on two clocks in a row.
- R2: `mc_stb` is a one-clock pulse every 12 oscillator clocks. The cycle after reset restarts from phase zero: the first pulse comes 12 clocks after the clock edge at which `rst_int` falls.
- R3: `port_preset` is high in the same cycle as `rst_pin`, with no register in the path. It stays high for as long as `rst_int` is high.
- R4: `rst_int` rises at the 24th consecutive clock edge that samples `rst_pin` high, which is two machine cycles. A pulse of 23 clocks or fewer leaves `rst_int` low. `rst_int` falls at the first edge that samples the pin low.
- R5: `mode_bits` reads 2'b00 after reset. Bit 0 is the idle request and bit 1 the power-down request. A `req_wr` pulse with `req_bits` = 2'b01 enters idle: `cpu_en` stops, while `periph_en` and `mc_stb` keep running.
- R6: In idle, `irq_pend` high at a clock edge clears bit 0 of `mode_bits` at that edge. `cpu_en` resumes only after the next `mc_stb` pulse: its first pulse comes two clocks after that strobe.
- R7: A write with bit 1 set enters power-down, and this wins over bit 0 when both are set. In power-down, `cpu_en`, `periph_en` and `mc_stb` stay low, and `irq_pend` has no effect.
- R8: An internal reset from idle or power-down returns the block to running with `mode_bits` = 2'b00 and the machine-cycle phase restarted.
- R9: While the CPU is stopped (idle or power-down), a `req_wr` pulse leaves `mode_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw external reset pin, active high |
| req_wr | input | 1 | Write strobe for the low-power request bits |
| req_bits | input | 2 | Write data: bit 0 requests idle, bit 1 requests power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | Clock enable for timers, serial port and interrupt logic |
| mc_stb | output | 1 | Machine-cycle boundary strobe |
| rst_int | output | 1 | Qualified internal reset |
| port_preset | output | 1 | Forces all port outputs to 1 |
| mode_bits | output | 2 | Current low-power request bits |

## Verification
The bench uses the default build: twelve oscillator clocks per machine cycle and a two-cycle qualification window. With these values the exact 24-clock threshold can be tested directly. Directed pulses of 23 and 24 clocks fall on either side of it, and random pulse lengths from 18 to 29 clocks cross it many times. Because the machine cycle is short, random interrupt wakes and mode writes land on every one of the twelve phases. This checks the boundary-aligned resume and the timing of entry into power-down in every alignment.

// File: rtl/cpm_pkg.sv
package cpm_pkg;
  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_WAKE = 2'd2,
    PM_DOWN = 2'd3
  } pm_state_e;

  localparam int unsigned REQ_IDLE_BIT = 0;
  localparam int unsigned REQ_DOWN_BIT = 1;
  localparam int unsigned REQ_W        = 2;
endpackage

// File: rtl/cpm_rst_qual.sv
module cpm_rst_qual #(
  parameter int unsigned QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic pin_i,
  output logic rst_o,
  output logic preset_o
);
  localparam int unsigned CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CLKS - 1);
  localparam logic [CW-1:0] FULL = CW'(QUAL_CLKS);

  logic [CW-1:0] hold_q = '0;
  logic          rst_q  = 1'b0;

  // Saturating count of consecutive edges with the pin high.
  always_ff @(posedge clk) begin
    if (!pin_i) begin
      hold_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (hold_q != FULL) hold_q <= hold_q + CW'(1);
      if (hold_q == LAST) rst_q <= 1'b1;
    end
  end

  assign rst_o    = rst_q;
  // Ports go high at once, long before qualification completes.
  assign preset_o = pin_i | rst_q;

  // R4: internal reset only appears once the whole window has elapsed
  a_r4_full_hold: assert property (@(posedge clk) disable iff (!pin_i)
    $rose(rst_q) |-> (hold_q == FULL));
endmodule

// File: rtl/cpm_divider.sv
module cpm_divider #(
  parameter int unsigned OSC_PER_MC = 12
) (
  input  logic clk,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o,
  output logic wrap_o,
  output logic stb_o,
  output logic per_en_o
);
  localparam int unsigned STATES = OSC_PER_MC / 2;
  localparam int unsigned SW     = (STATES > 1) ? $clog2(STATES) : 1;
  localparam logic [SW-1:0] S_LAST = SW'(STATES - 1);

  logic          half_q = 1'b0;
  logic [SW-1:0] st_q   = '0;
  logic          stb_q  = 1'b0;
  logic          per_q  = 1'b0;

  // Divide-by-two toggle, then the state counter advances on its odd phase.
  always_ff @(posedge clk) begin
    if (clr_i) begin
      half_q <= 1'b0;
      st_q   <= '0;
    end else if (run_i) begin
      half_q <= ~half_q;
      if (half_q) st_q <= (st_q == S_LAST) ? '0 : st_q + SW'(1);
    end
  end

  assign tick_o = run_i & half_q & ~clr_i;
  assign wrap_o = tick_o & (st_q == S_LAST);

  always_ff @(posedge clk) begin
    if (clr_i) begin
      stb_q <= 1'b0;
      per_q <= 1'b0;
    end else begin
      stb_q <= wrap_o;
      per_q <= tick_o;
    end
  end

  assign stb_o    = stb_q;
  assign per_en_o = per_q;

  // R2: boundary strobe lasts one clock
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (clr_i)
    stb_q |=> !stb_q);
  // R1: peripheral enable at half rate, never two in a row
  a_r1_half_rate: assert property (@(posedge clk) disable iff (clr_i)
    per_q |=> !per_q);
endmodule

// File: rtl/cpm_mode.sv
module cpm_mode
  import cpm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_i,
  input  logic             wr_i,
  input  logic [REQ_W-1:0] wdata_i,
  input  logic             irq_i,
  input  logic             tick_i,
  input  logic             wrap_i,
  output pm_state_e        state_o,
  output logic [REQ_W-1:0] bits_o,
  output logic             cpu_en_o
);
  pm_state_e        st_q   = PM_RUN;
  logic [REQ_W-1:0] bits_q = '0;
  logic             cpu_q  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst_i) begin
      st_q   <= PM_RUN;
      bits_q <= '0;
      cpu_q  <= 1'b0;
    end else begin
      cpu_q <= tick_i && (st_q == PM_RUN);
      unique case (st_q)
        PM_RUN: begin
          if (wr_i) begin
            bits_q <= wdata_i;
            if (wdata_i[REQ_DOWN_BIT])      st_q <= PM_DOWN;
            else if (wdata_i[REQ_IDLE_BIT]) st_q <= PM_IDLE;
          end
        end
        PM_IDLE: begin
          if (irq_i) begin
            bits_q[REQ_IDLE_BIT] <= 1'b0;
            st_q                 <= PM_WAKE;
          end
        end
        PM_WAKE: begin
          if (wrap_i) st_q <= PM_RUN;
        end
        default: st_q <= PM_DOWN;
      endcase
    end
  end

  assign state_o  = st_q;
  assign bits_o   = bits_q;
  assign cpu_en_o = cpu_q;

  // R7: power-down is left only through reset
  a_r7_down_sticky: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == PM_DOWN) |=> (st_q == PM_DOWN));
  // R6: interrupt wake clears the idle request
  a_r6_wake_clears: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == PM_IDLE && irq_i) |=> !bits_q[REQ_IDLE_BIT]);
  // R9: request bits frozen while the CPU is stopped and nothing wakes it
  a_r9_no_write_stopped: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == PM_DOWN || (st_q == PM_IDLE && !irq_i)) |=> $stable(bits_q));
  // R5: no CPU enable once idle has settled
  a_r5_cpu_stops: assert property (@(posedge clk) disable iff (rst_i)
    (st_q == PM_IDLE && $past(st_q) == PM_IDLE) |-> !cpu_q);
endmodule

// File: rtl/clkpwr_ctrl.sv
module clkpwr_ctrl
  import cpm_pkg::*;
#(
  parameter int unsigned OSC_PER_MC = 12,
  parameter int unsigned QUAL_MC    = 2
) (
  input  logic       osc_clk,
  input  logic       rst_pin,
  input  logic       req_wr,
  input  logic [1:0] req_bits,
  input  logic       irq_pend,
  output logic       cpu_en,
  output logic       periph_en,
  output logic       mc_stb,
  output logic       rst_int,
  output logic       port_preset,
  output logic [1:0] mode_bits
);
  localparam int unsigned QUAL_CLKS = OSC_PER_MC * QUAL_MC;

  pm_state_e st;
  logic      run;
  logic      tick;
  logic      wrap;

  cpm_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_qual (
    .clk      (osc_clk),
    .pin_i    (rst_pin),
    .rst_o    (rst_int),
    .preset_o (port_preset)
  );

  assign run = !rst_int && (st != PM_DOWN);

  cpm_divider #(.OSC_PER_MC(OSC_PER_MC)) u_div (
    .clk      (osc_clk),
    .clr_i    (rst_int),
    .run_i    (run),
    .tick_o   (tick),
    .wrap_o   (wrap),
    .stb_o    (mc_stb),
    .per_en_o (periph_en)
  );

  cpm_mode u_mode (
    .clk      (osc_clk),
    .rst_i    (rst_int),
    .wr_i     (req_wr),
    .wdata_i  (req_bits),
    .irq_i    (irq_pend),
    .tick_i   (tick),
    .wrap_i   (wrap),
    .state_o  (st),
    .bits_o   (mode_bits),
    .cpu_en_o (cpu_en)
  );

  // R5: CPU enable never appears without the peripheral enable
  a_r5_cpu_within_periph: assert property (@(posedge osc_clk) disable iff (rst_int)
    cpu_en |-> periph_en);
  // R7: settled power-down keeps every enable and strobe low
  a_r7_down_quiet: assert property (@(posedge osc_clk) disable iff (rst_int)
    (st == PM_DOWN && $past(st) == PM_DOWN) |-> !(cpu_en || periph_en || mc_stb));
endmodule

// File: tb/test_clkpwr_ctrl.sv
module test_clkpwr_ctrl;
  localparam int MC   = 12;
  localparam int QM   = 2;
  localparam int QCLK = MC * QM;

  logic       osc_clk = 1'b0;
  logic       rst_pin = 1'b0;
  logic       req_wr = 1'b0;
  logic [1:0] req_bits = 2'b00;
  logic       irq_pend = 1'b0;
  logic       cpu_en, periph_en, mc_stb, rst_int, port_preset;
  logic [1:0] mode_bits;

  always #2 osc_clk = ~osc_clk;

  clkpwr_ctrl #(.OSC_PER_MC(MC), .QUAL_MC(QM)) i_clkpwr_ctrl (
    .osc_clk(osc_clk), .rst_pin(rst_pin), .req_wr(req_wr), .req_bits(req_bits),
    .irq_pend(irq_pend), .cpu_en(cpu_en), .periph_en(periph_en), .mc_stb(mc_stb),
    .rst_int(rst_int), .port_preset(port_preset), .mode_bits(mode_bits)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  // Reference model built from the requirements
  typedef enum int {S_RUN, S_IDLE, S_WAKE, S_DOWN} mst_t;
  int       m_hold = 0;
  bit       m_rst = 1'b0;
  int       m_cnt = 0;
  mst_t     m_st = S_RUN;
  bit [1:0] m_bits = 2'b00;
  bit       e_cpu = 1'b0, e_per = 1'b0, e_stb = 1'b0;

  function automatic bit f_run(bit r, mst_t s);
    return !r && (s != S_DOWN);
  endfunction

  always @(posedge osc_clk) begin : model
    bit run_b, tick_b, wrap_b;
    run_b  = f_run(m_rst, m_st);
    tick_b = run_b && (m_cnt % 2 == 1);
    wrap_b = run_b && (m_cnt == MC - 1);
    e_stb <= wrap_b;
    e_per <= tick_b;
    e_cpu <= tick_b && (m_st == S_RUN);
    if (m_rst) m_cnt <= 0;
    else if (run_b) m_cnt <= (m_cnt + 1) % MC;
    if (m_rst) begin
      m_st   <= S_RUN;
      m_bits <= 2'b00;
    end else begin
      case (m_st)
        S_RUN: if (req_wr) begin
          m_bits <= req_bits;
          if (req_bits[1]) m_st <= S_DOWN;
          else if (req_bits[0]) m_st <= S_IDLE;
        end
        S_IDLE: if (irq_pend) begin
          m_bits[0] <= 1'b0;
          m_st      <= S_WAKE;
        end
        S_WAKE: if (wrap_b) m_st <= S_RUN;
        default: ;
      endcase
    end
    if (!rst_pin) begin
      m_hold <= 0;
      m_rst  <= 1'b0;
    end else begin
      if (m_hold < QCLK) m_hold <= m_hold + 1;
      if (m_hold >= QCLK - 1) m_rst <= 1'b1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge osc_clk);
    chk("R3", "port_preset", int'(port_preset), int'(rst_pin | m_rst));
    chk("R4", "rst_int", int'(rst_int), int'(m_rst));
    chk("R2", "mc_stb", int'(mc_stb), int'(e_stb));
    chk("R1", "periph_en", int'(periph_en), int'(e_per));
    chk("R5", "cpu_en", int'(cpu_en), int'(e_cpu));
    chk("R6", "mode_bits", int'(mode_bits), int'(m_bits));
  endtask

  task automatic hold_pin(input int len);
    rst_pin = 1'b1;
    repeat (len) step();
    rst_pin = 1'b0;
  endtask

  task automatic write_req(input logic [1:0] b);
    req_wr = 1'b1;
    req_bits = b;
    step();
    req_wr = 1'b0;
    req_bits = 2'b00;
  endtask

  task automatic release_and_measure(input string req);
    int n;
    rst_pin = 1'b0;
    step();
    n = 0;
    do begin
      step();
      n++;
    end while (!mc_stb && n < 100);
    chk(req, "clocks from release to first strobe", n, MC);
  endtask

  always @(posedge osc_clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int n, c_cpu, c_per, c_stb;
    bit seen;
    void'($urandom(32'd4242));

    // Reset state and immediate preset (R3, R4)
    step();
    chk("R5", "mode_bits at start", int'(mode_bits), 0);
    rst_pin = 1'b1;
    #1 chk("R3", "preset follows pin at once", int'(port_preset), 1);
    n = 0;
    do begin
      step();
      n++;
    end while (!rst_int && n < 100);
    chk("R4", "edges until internal reset", n, QCLK);
    repeat (5) step();
    release_and_measure("R2");

    // Short pulse never qualifies (R4)
    repeat (7) step();
    rst_pin = 1'b1;
    seen = 1'b0;
    repeat (QCLK - 1) begin
      step();
      if (rst_int) seen = 1'b1;
    end
    rst_pin = 1'b0;
    step();
    chk("R4", "23-clock pulse qualified", int'(seen | rst_int), 0);

    // Half-rate peripheral enable (R1)
    c_per = 0;
    repeat (2 * MC) begin
      step();
      if (periph_en) c_per++;
    end
    chk("R1", "enables per two machine cycles", c_per, MC);

    // Idle entry (R5)
    write_req(2'b01);
    chk("R5", "idle request bit", int'(mode_bits), 1);
    step();
    c_cpu = 0; c_per = 0; c_stb = 0;
    repeat (30) begin
      step();
      if (cpu_en) c_cpu++;
      if (periph_en) c_per++;
      if (mc_stb) c_stb++;
    end
    chk("R5", "cpu enables in idle", c_cpu, 0);
    chk("R5", "periph enables in idle", c_per, 15);
    chk("R5", "strobes keep running in idle", int'(c_stb >= 2), 1);

    // Write while idle is ignored (R9)
    write_req(2'b00);
    step();
    chk("R9", "bits after write in idle", int'(mode_bits), 1);

    // Interrupt wake aligned to boundary (R6)
    irq_pend = 1'b1;
    step();
    irq_pend = 1'b0;
    chk("R6", "idle bit after wake", int'(mode_bits), 0);
    seen = 1'b0;
    n = 0;
    c_cpu = 0;
    do begin
      step();
      if (seen) n++;
      if (mc_stb) seen = 1'b1;
      if (cpu_en) c_cpu++;
    end while (!(cpu_en && seen) && c_cpu == 0 && n < 100);
    chk("R6", "strobe before first cpu enable", int'(seen), 1);
    chk("R6", "clocks from strobe to cpu enable", n, 2);

    // Power-down with both bits set (R7, R9)
    repeat (5) step();
    write_req(2'b11);
    chk("R7", "bits in power-down", int'(mode_bits), 3);
    repeat (2) step();
    c_cpu = 0; c_per = 0; c_stb = 0;
    for (int i = 0; i < 40; i++) begin
      irq_pend = (i % 3 == 0);
      req_wr = (i % 7 == 0);
      req_bits = 2'b01;
      step();
      if (cpu_en) c_cpu++;
      if (periph_en) c_per++;
      if (mc_stb) c_stb++;
    end
    irq_pend = 1'b0; req_wr = 1'b0; req_bits = 2'b00;
    step();
    chk("R7", "enables and strobes in power-down", c_cpu + c_per + c_stb, 0);
    chk("R9", "bits after writes in power-down", int'(mode_bits), 3);

    // Reset exits power-down (R8)
    hold_pin(QCLK + 3);
    chk("R8", "bits after reset", int'(mode_bits), 0);
    release_and_measure("R8");

    // Random traffic checked against the model
    for (int k = 0; k < 5000; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) hold_pin(18 + int'($urandom % 12));
      else if (r < 6) write_req(2'($urandom));
      else begin
        irq_pend = ($urandom % 8 == 0);
        step();
        irq_pend = 1'b0;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule